// File: doc/BRIEF.md
# Cascaded Multi-Rate Tick Generator

This block turns one fast system clock into three slower timing references, all kept inside the system clock domain. For each rate it gives a strobe that is high for exactly one system cycle per period, for use as a clock enable by downstream registers. It also gives a registered square wave with a 50% duty cycle at the same rate. The default setting takes a 50 MHz clock and makes rates of 8 kHz, 2 Hz and 1 Hz.

A prescaler counter runs on every cycle and makes the fast strobe when it reaches its last count. A second counter moves forward only on that fast strobe. The two slow strobes are decoded from fixed values of this second counter, and only in a cycle where the fast strobe is high. Each counter wraps back to zero on the clock edge after its last value, so no preset is ever fed back from the count. The square waves toggle at half-period points, which keeps their duty cycle at exactly 50% even though the divide ratios are not powers of two.

The divide ratios are worked out from the frequency parameters when the design is elaborated. Elaboration stops if any ratio is not an exact integer, or if a ratio is odd where a square wave needs an even half period.

Top module: `tick_gen`

In the requirements, P is CLK_HZ/FAST_HZ, M is FAST_HZ/MID_HZ and S is FAST_HZ/SLOW_HZ. Cycle c is counted from the first clock edge after reset is released, with c = 0 meaning the state before that edge. All strobes and squares are active high.

## Requirements
- R1: `tick_fast_o` is 1 in exactly the cycles where c mod P = P-1. The pulse is one cycle wide and the period is P cycles.
- R2: `tick_mid_o` is 1 in exactly the cycles where c mod (P*M) = P*M-1, so the period is P*M cycles.
- R3: `tick_slow_o` is 1 in exactly the cycles where c mod (P*S) = P*S-1, so the period is P*S cycles.
- R4: `tick_mid_o` and `tick_slow_o` are only ever high in a cycle where `tick_fast_o` is high. Every slow pulse lands on a mid pulse.
- R5: `sq_fast_o` is equal to floor(c/(P/2)) mod 2. This is a 50% square with period P that first rises at c = P/2.
- R6: `sq_mid_o` is equal to floor(c/(P*M/2)) mod 2, and it changes only on the edge right after a fast strobe.
- R7: `sq_slow_o` is equal to floor(c/(P*S/2)) mod 2.
- R8: Pulling `rst_ni` low at any time clears all six outputs to 0 at once. After release, every output follows R1 to R7 again from c = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_fast_o | output | 1 | One-cycle strobe at FAST_HZ |
| tick_mid_o | output | 1 | One-cycle strobe at MID_HZ |
| tick_slow_o | output | 1 | One-cycle strobe at SLOW_HZ |
| sq_fast_o | output | 1 | 50% square at FAST_HZ |
| sq_mid_o | output | 1 | 50% square at MID_HZ |
| sq_slow_o | output | 1 | 50% square at SLOW_HZ |

## Verification
The assertions assume that the clock runs freely, that reset is the only input that changes, and that the ratio parameters meet the divisibility rules checked at elaboration. The stimulus follows these assumptions. It changes `rst_ni` only at falling clock edges, holds it low for several cycles at a time, and never drives anything else. The bench uses two small settings, one with M < S and one with a slow divide that is not a multiple of two mid periods. In each setting it compares every output on every cycle with the closed-form expressions over several full slow periods. It does this both from power-up and again after a reset applied in the middle of a run.

// File: rtl/tick_pkg.sv
package tick_pkg;
  function automatic bit ratio_ok(input longint unsigned num, input longint unsigned den);
    return (den != 0) && (num >= den) && ((num % den) == 0);
  endfunction

  function automatic bit is_even(input longint unsigned v);
    return (v % 2) == 0;
  endfunction
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned MOD = 4,
  localparam int unsigned W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_tap.sv
// Decodes a strobe and a 50% square from the second-stage counter.
module tick_tap #(
  parameter int unsigned SPAN = 8,
  parameter int unsigned DIV  = 4,
  parameter int unsigned W    = 3,
  localparam int unsigned N_TICK = SPAN / DIV,
  localparam int unsigned N_HALF = 2 * N_TICK,
  localparam int unsigned HALF   = DIV / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fast_i,
  input  logic [W-1:0] cnt_i,
  output logic         tick_o,
  output logic         sq_o
);
  logic [N_TICK-1:0] hit_tick;
  logic [N_HALF-1:0] hit_half;
  logic              sq_q;

  for (genvar k = 0; k < N_TICK; k++) begin : g_tick
    assign hit_tick[k] = (cnt_i == W'((k + 1) * DIV - 1));
  end

  for (genvar k = 0; k < N_HALF; k++) begin : g_half
    assign hit_half[k] = (cnt_i == W'((k + 1) * HALF - 1));
  end

  assign tick_o = fast_i && (|hit_tick);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     sq_q <= 1'b0;
    else if (fast_i && (|hit_half))  sq_q <= ~sq_q;
  end

  assign sq_o = sq_q;
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned FAST_HZ = 8_000,
  parameter int unsigned MID_HZ  = 2,
  parameter int unsigned SLOW_HZ = 1,
  localparam int unsigned PRE_DIV = CLK_HZ / FAST_HZ,
  localparam int unsigned MID_DIV = FAST_HZ / MID_HZ,
  localparam int unsigned SEC_DIV = FAST_HZ / SLOW_HZ,
  localparam int unsigned PRE_W   = $clog2(PRE_DIV),
  localparam int unsigned SEC_W   = $clog2(SEC_DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_fast_o,
  output logic tick_mid_o,
  output logic tick_slow_o,
  output logic sq_fast_o,
  output logic sq_mid_o,
  output logic sq_slow_o
);
  import tick_pkg::*;

  localparam bit CFG_OK = ratio_ok(CLK_HZ, FAST_HZ) && ratio_ok(FAST_HZ, MID_HZ)
                       && ratio_ok(FAST_HZ, SLOW_HZ) && ratio_ok(SEC_DIV, MID_DIV)
                       && is_even(PRE_DIV) && is_even(MID_DIV) && is_even(SEC_DIV);

  if (!CFG_OK) begin : g_bad_cfg
    $error("tick_gen: divide ratios must be exact even integers, slow a multiple of mid");
  end

  logic [PRE_W-1:0] pre_cnt;
  logic [SEC_W-1:0] sec_cnt;
  logic             fast_tick;
  logic             sec_wrap;
  logic             fast_sq_q;

  tick_counter #(.MOD(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .cnt_o  (pre_cnt),
    .wrap_o (fast_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fast_sq_q <= 1'b0;
    else if (fast_tick || (pre_cnt == PRE_W'(PRE_DIV / 2 - 1))) fast_sq_q <= ~fast_sq_q;
  end

  // advances only on the fast strobe
  tick_counter #(.MOD(SEC_DIV)) u_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fast_tick),
    .cnt_o  (sec_cnt),
    .wrap_o (sec_wrap)
  );

  tick_tap #(.SPAN(SEC_DIV), .DIV(MID_DIV), .W(SEC_W)) u_mid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (fast_tick),
    .cnt_i  (sec_cnt),
    .tick_o (tick_mid_o),
    .sq_o   (sq_mid_o)
  );

  logic slow_tick;

  tick_tap #(.SPAN(SEC_DIV), .DIV(SEC_DIV), .W(SEC_W)) u_slow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (fast_tick),
    .cnt_i  (sec_cnt),
    .tick_o (slow_tick),
    .sq_o   (sq_slow_o)
  );

  assign tick_fast_o = fast_tick;
  assign tick_slow_o = slow_tick && sec_wrap;
  assign sq_fast_o   = fast_sq_q;
endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned FAST_HZ = 8_000,
  parameter int unsigned MID_HZ  = 2,
  parameter int unsigned SLOW_HZ = 1,
  localparam int unsigned PRE_DIV = CLK_HZ / FAST_HZ,
  localparam int unsigned PW = $clog2(PRE_DIV) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_fast_o,
  input logic tick_mid_o,
  input logic tick_slow_o,
  input logic sq_fast_o,
  input logic sq_mid_o,
  input logic sq_slow_o
);
  logic [PW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (tick_fast_o) gap_q <= '0;
    else                  gap_q <= gap_q + 1'b1;
  end

  // R1
  fast_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_fast_o |-> (gap_q == PW'(PRE_DIV - 1)));

  // R1
  fast_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_fast_o |=> !tick_fast_o);

  // R4
  mid_on_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_mid_o |-> tick_fast_o);

  // R4
  slow_on_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_o |-> tick_mid_o);

  // R5
  fast_sq_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_fast_o |=> (sq_fast_o != $past(sq_fast_o)));

  // R6
  mid_sq_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sq_mid_o) |-> $past(tick_fast_o));

  // R7
  slow_sq_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_o |=> (sq_slow_o != $past(sq_slow_o)));

  // R8
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(tick_fast_o || tick_mid_o || tick_slow_o || sq_fast_o || sq_mid_o || sq_slow_o));
endmodule

bind tick_gen tick_gen_chk #(
  .CLK_HZ(CLK_HZ), .FAST_HZ(FAST_HZ), .MID_HZ(MID_HZ), .SLOW_HZ(SLOW_HZ)
) u_chk (.*);

// File: tb/sim_tick_gen.sv
`timescale 1ns/1ps
module sim_tick_gen;
  // setting A: P=12 M=4 S=8 ; setting B: P=6 M=2 S=10
  localparam int A_P = 12, A_M = 4, A_S = 8;
  localparam int B_P = 6,  B_M = 2, B_S = 10;
  localparam int SWEEP = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_tf, a_tm, a_ts, a_sf, a_sm, a_ss;
  logic b_tf, b_tm, b_ts, b_sf, b_sm, b_ss;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_gen #(.CLK_HZ(96), .FAST_HZ(8), .MID_HZ(2), .SLOW_HZ(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_fast_o(a_tf), .tick_mid_o(a_tm), .tick_slow_o(a_ts),
    .sq_fast_o(a_sf), .sq_mid_o(a_sm), .sq_slow_o(a_ss));

  tick_gen #(.CLK_HZ(60), .FAST_HZ(10), .MID_HZ(5), .SLOW_HZ(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_fast_o(b_tf), .tick_mid_o(b_tm), .tick_slow_o(b_ts),
    .sq_fast_o(b_sf), .sq_mid_o(b_sm), .sq_slow_o(b_ss));

  task automatic chk(input logic act, input logic exp, input string tag, input int c);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, c, act, exp);
    end
  endtask

  task automatic check_cfg(input string nm, input int c, input int p, input int m, input int s,
                           input logic tf, input logic tm, input logic ts,
                           input logic sf, input logic sm, input logic ss);
    chk(tf, (c % p) == p - 1,             {"R1 tick_fast ", nm}, c);
    chk(tm, (c % (p*m)) == p*m - 1,       {"R2 tick_mid ", nm}, c);
    chk(ts, (c % (p*s)) == p*s - 1,       {"R3 tick_slow ", nm}, c);
    chk(sf, ((c / (p/2)) % 2) == 1,       {"R5 sq_fast ", nm}, c);
    chk(sm, ((c / (p*m/2)) % 2) == 1,     {"R6 sq_mid ", nm}, c);
    chk(ss, ((c / (p*s/2)) % 2) == 1,     {"R7 sq_slow ", nm}, c);
    // R4: slow strobes only with fast strobe
    if (tm || ts) chk(tf, 1'b1, {"R4 on-fast ", nm}, c);
  endtask

  task automatic check_zero(input string tag);
    chk(a_tf | a_tm | a_ts, 1'b0, {"R8 ticks A ", tag}, -1);
    chk(a_sf | a_sm | a_ss, 1'b0, {"R8 squares A ", tag}, -1);
    chk(b_tf | b_tm | b_ts, 1'b0, {"R8 ticks B ", tag}, -1);
    chk(b_sf | b_sm | b_ss, 1'b0, {"R8 squares B ", tag}, -1);
  endtask

  task automatic sweep(input int n);
    for (int c = 0; c < n; c++) begin
      check_cfg("A", c, A_P, A_M, A_S, a_tf, a_tm, a_ts, a_sf, a_sm, a_ss);
      check_cfg("B", c, B_P, B_M, B_S, b_tf, b_tm, b_ts, b_sf, b_sm, b_ss);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_zero("power-up");
    rst_n = 1'b1;
    sweep(SWEEP);
    // R8: asynchronous mid-run reset
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_zero("async assert");
    repeat (4) @(negedge clk);
    check_zero("held");
    rst_n = 1'b1;
    sweep(SWEEP);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule